// File: doc/BRIEF.md
# Row/Column Multiplexed DRAM Controller with Refresh

This controller sits between a processor-side request port and a DRAM whose address pins carry the row and the column at different times. The requester presents a flat address, made of a row field above a column field, together with a read or write flag and an optional burst flag. It holds the request until the controller answers with a one-cycle ready pulse. The controller opens the row under the active-low row strobe. After a parameterised activation delay it presents the column under the active-low column strobe. A read word arrives on the DRAM data bus one cycle after its column strobe and is registered onto the read port one cycle later.

A row stays open after an access. A follow-up to the same row issues only a column strobe. An access to a different row first spends one cycle with the row strobe released, then reopens. A read burst issues four back-to-back column strobes, and the controller steps the column by one for each of them.

A refresh timer raises a pending flag once every programmable interval. The pending refresh waits for the access in flight to finish and closes any open row. It then holds the row strobe low on the next refresh row for a fixed number of cycles, with the column strobe idle. No new request is accepted while a refresh is pending or running.

Top module: `dram_ctrl`

## Requirements
- R1: The controller alone splits `addr_i`. The upper `ROW_W` bits go out on `dram_addr_o` while the row strobe falls, and the lower `COL_W` bits go out while the column strobe is low. Both are zero-extended to the bus width.
- R2: `ras_no`, `cas_no` and `we_no` are active low. Under reset `ras_no`, `cas_no` and `we_no` are 1, and `ready_o`, `rvalid_o` and `dq_oe_o` are 0. The column strobe is only ever low while the row strobe is low.
- R3: After the row strobe falls, at least `T_RCD` cycles pass before the first column strobe. On a closed row the first column strobe comes exactly `T_RCD` cycles after acceptance plus one.
- R4: For a read, `dq_i` is sampled one cycle after the column strobe and appears on `rdata_o` with `rvalid_o` one cycle after that. For a write, `we_no` is low, `dq_oe_o` is high and `dq_o` carries the write data in the column-strobe cycle.
- R5: A read with `burst_i` set gives `BURST_LEN` (4) consecutive column strobes at columns c, c+1, ... modulo 2^`COL_W`, and returns `BURST_LEN` valid words. On a write, `burst_i` is ignored and exactly one word is written.
- R6: An access to the open row issues no row strobe; its column strobe follows acceptance by one cycle. An access to another row first releases the row strobe for one cycle.
- R7: A request is accepted when `req_i` is high, `ready_o` is low and no refresh is pending. `ready_o` is a single-cycle pulse after the write, or with the final read word. Counted in clock edges from the acceptance edge to the ready cycle, the latency is 2 (write) or 3 (single read) or `BURST_LEN`+2 (burst read). A closed row adds `T_RCD`, and a row change adds `T_RCD`+1.
- R8: Every `REF_INT` cycles a refresh becomes pending. A refresh holds the row strobe low for exactly `REF_CYC` cycles with no column strobe, on a refresh row counter that starts at 0 and wraps after `REF_ROWS` rows.
- R9: A pending refresh waits for the current access or burst to finish and closes the open row, and it blocks new requests until it has finished. The first access after a refresh sees a closed row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| burst_i | input | 1 | Read burst of BURST_LEN words |
| addr_i | input | ROW_W+COL_W | Flat address {row, column} |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read word |
| rvalid_o | output | 1 | rdata_o valid |
| dram_addr_o | output | max(ROW_W,COL_W,clog2(REF_ROWS)) | Shared row/column address bus |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| dq_o | output | DATA_W | Write data to DRAM |
| dq_oe_o | output | 1 | dq_o drive enable |
| dq_i | input | DATA_W | Read data from DRAM |

## Verification
The bench drives a cycle-based DRAM model. The model latches the row at each falling row strobe and flags any column strobe that comes too early or with the row closed. It records every row-strobe window that had no column strobe as a refresh, together with its length and row. Latency is measured for closed-row, same-row and changed-row accesses. A controller that reselected an open row, or skipped the precharge cycle, would miss the exact counts. A burst that starts at the last column must wrap to column 0, and a design that carried into the row would return wrong data. A write with the burst flag set must touch one word only, which a following read of the next column exposes. Refreshes must walk the rows and wrap, stay a fixed interval apart and close the open row. A stream of mixed traffic across refreshes would show any refresh cut into a burst as a model violation or as corrupted data.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_RDW,
    ST_REF
  } st_e;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int REF_INT  = 1000,
  parameter int REF_ROWS = 8192,
  localparam int REF_W   = $clog2(REF_ROWS),
  localparam int TMR_W   = $clog2(REF_INT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  output logic             pend_o,
  output logic [REF_W-1:0] row_o
);

  logic [TMR_W-1:0] tmr_q;
  logic             expire;

  assign expire = (tmr_q == TMR_W'(REF_INT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      pend_o <= 1'b0;
      row_o  <= '0;
    end else begin
      tmr_q <= expire ? '0 : tmr_q + 1'b1;
      if (expire)      pend_o <= 1'b1;
      else if (done_i) pend_o <= 1'b0;
      if (done_i) row_o <= (row_o == REF_W'(REF_ROWS - 1)) ? '0 : row_o + 1'b1;
    end
  end

  // R8
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !done_i) |=> pend_o);

endmodule

// File: rtl/dram_rd_capture.sv
module dram_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              s1_last_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              done_o
);

  logic s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q      <= 1'b0;
      s1_last_o <= 1'b0;
      rdata_o   <= '0;
      rvalid_o  <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      s1_q      <= issue_i;
      s1_last_o <= issue_i && last_i;
      rvalid_o  <= s1_q;
      done_o    <= s1_last_o;
      if (s1_q) rdata_o <= dq_i;
    end
  end

  // R4
  rvalid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(issue_i, 2));

endmodule

// File: rtl/dram_cmd_fsm.sv
module dram_cmd_fsm import dram_ctrl_pkg::*; #(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 16,
  parameter int REF_W     = 13,
  parameter int AB_W      = 13,
  parameter int T_RCD     = 2,
  parameter int BURST_LEN = 4,
  parameter int REF_CYC   = 4,
  localparam int AW       = ROW_W + COL_W,
  localparam int CNT_W    = $clog2(T_RCD + BURST_LEN + REF_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              burst_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  input  logic              ref_pend_i,
  input  logic [REF_W-1:0]  ref_row_i,
  input  logic              s1_last_i,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [AB_W-1:0]   addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              rd_issue_o,
  output logic              rd_last_o,
  output logic              wr_done_o,
  output logic              ref_done_o
);

  st_e                st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, beats_m1;
  logic               open_q, pre_ref_q, we_q, burst_q;
  logic [ROW_W-1:0]   row_q;
  logic [COL_W-1:0]   col_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               accept, hit, last_beat;

  assign hit       = open_q && (addr_i[AW-1:COL_W] == row_q);
  assign accept    = (st_q == ST_IDLE) && req_i && !ready_i && !ref_pend_i;
  assign beats_m1  = (burst_q && !we_q) ? CNT_W'(BURST_LEN - 1) : '0;
  assign last_beat = (cnt_q == beats_m1);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (ref_pend_i)  st_d = open_q ? ST_PRE : ST_REF;
               else if (accept) st_d = hit ? ST_COL : (open_q ? ST_PRE : ST_ACT);
      ST_PRE:  st_d = pre_ref_q ? ST_REF : ST_ACT;
      ST_ACT:  if (cnt_q == CNT_W'(T_RCD - 1)) st_d = ST_COL;
      ST_COL:  if (last_beat) st_d = we_q ? ST_IDLE : ST_RDW;
      ST_RDW:  if (s1_last_i) st_d = ST_IDLE;
      ST_REF:  if (cnt_q == CNT_W'(REF_CYC - 1)) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      open_q    <= 1'b0;
      pre_ref_q <= 1'b0;
      we_q      <= 1'b0;
      burst_q   <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      wdata_q   <= '0;
      wr_done_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= (st_d != st_q) ? '0 : cnt_q + 1'b1;
      wr_done_o <= (st_q == ST_COL) && we_q;
      if (st_q == ST_IDLE) pre_ref_q <= ref_pend_i;
      if (accept) begin
        row_q   <= addr_i[AW-1:COL_W];
        col_q   <= addr_i[COL_W-1:0];
        we_q    <= we_i;
        burst_q <= burst_i;
        wdata_q <= wdata_i;
      end
      if (st_d == ST_ACT && st_q != ST_ACT) open_q <= 1'b1;
      else if (st_d == ST_PRE)              open_q <= 1'b0;
    end
  end

  // row strobe low while a row is held open or a refresh runs
  assign ras_no     = !(open_q || st_q == ST_REF);
  assign cas_no     = (st_q != ST_COL);
  assign we_no      = !((st_q == ST_COL) && we_q);
  assign dq_oe_o    = (st_q == ST_COL) && we_q;
  assign dq_o       = wdata_q;
  assign rd_issue_o = (st_q == ST_COL) && !we_q;
  assign rd_last_o  = last_beat;
  assign ref_done_o = (st_q == ST_REF) && (cnt_q == CNT_W'(REF_CYC - 1));

  always_comb begin
    unique case (st_q)
      ST_REF:  addr_o = AB_W'(ref_row_i);
      ST_COL:  addr_o = AB_W'(col_q + COL_W'(cnt_q));
      default: addr_o = AB_W'(row_q);
    endcase
  end

  // R9
  ref_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && ref_pend_i) |=> (st_q == ST_PRE || st_q == ST_REF));

  // R6
  hit_reuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit) |=> (st_q == ST_COL && $stable(ras_no)));

  // R5
  burst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_COL && $past(st_q == ST_COL)) |->
      (addr_o[COL_W-1:0] == $past(addr_o[COL_W-1:0]) + COL_W'(1)));

endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl import dram_ctrl_pkg::*; #(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 16,
  parameter int T_RCD     = 2,
  parameter int BURST_LEN = 4,
  parameter int REF_INT   = 1000,
  parameter int REF_ROWS  = 8192,
  parameter int REF_CYC   = 4,
  localparam int AW       = ROW_W + COL_W,
  localparam int REF_W    = $clog2(REF_ROWS),
  localparam int AB_W     = max3(ROW_W, COL_W, REF_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              burst_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [AB_W-1:0]   dram_addr_o,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);

  localparam int RL_W = $clog2(T_RCD + 2);

  logic             ref_pend, ref_done, rd_issue, rd_last, s1_last, wr_done, rd_done;
  logic [REF_W-1:0] ref_row;

  dram_refresh_timer #(
    .REF_INT (REF_INT),
    .REF_ROWS(REF_ROWS)
  ) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_i(ref_done),
    .pend_o(ref_pend),
    .row_o (ref_row)
  );

  dram_cmd_fsm #(
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .DATA_W   (DATA_W),
    .REF_W    (REF_W),
    .AB_W     (AB_W),
    .T_RCD    (T_RCD),
    .BURST_LEN(BURST_LEN),
    .REF_CYC  (REF_CYC)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .burst_i   (burst_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .ready_i   (ready_o),
    .ref_pend_i(ref_pend),
    .ref_row_i (ref_row),
    .s1_last_i (s1_last),
    .ras_no    (ras_no),
    .cas_no    (cas_no),
    .we_no     (we_no),
    .addr_o    (dram_addr_o),
    .dq_o      (dq_o),
    .dq_oe_o   (dq_oe_o),
    .rd_issue_o(rd_issue),
    .rd_last_o (rd_last),
    .wr_done_o (wr_done),
    .ref_done_o(ref_done)
  );

  dram_rd_capture #(
    .DATA_W(DATA_W)
  ) i_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .issue_i  (rd_issue),
    .last_i   (rd_last),
    .dq_i     (dq_i),
    .s1_last_o(s1_last),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o),
    .done_o   (rd_done)
  );

  assign ready_o = wr_done || rd_done;

  // cycles the row strobe has been low, saturating
  logic [RL_W-1:0] ras_low_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ras_low_q <= '0;
    else if (ras_no)                        ras_low_q <= '0;
    else if (ras_low_q != RL_W'(T_RCD))     ras_low_q <= ras_low_q + 1'b1;
  end

  // R2
  cas_in_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> !ras_no);

  // R3
  rcd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> (ras_low_q >= RL_W'(T_RCD)));

  // R7
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

endmodule

// File: tb/test_dram_ctrl.sv
module test_dram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 12, COL_W = 9, DATA_W = 16;
  localparam int T_RCD = 2, BURST = 4, REF_INT = 400, REF_ROWS = 4, REF_CYC = 4;
  localparam int AW = ROW_W + COL_W, AB_W = 12, NCOL = 1 << COL_W;
  localparam int NVEC = 12;

  // {we, burst, row, col, wdata}
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 12'd5,    9'd10,  16'hA1A1},
    {1'b0, 1'b0, 12'd5,    9'd10,  16'h0000},
    {1'b1, 1'b0, 12'd5,    9'd11,  16'hB2B2},
    {1'b0, 1'b1, 12'd5,    9'd10,  16'h0000},
    {1'b0, 1'b0, 12'd9,    9'd0,   16'h0000},
    {1'b0, 1'b1, 12'd9,    9'd510, 16'h0000},
    {1'b1, 1'b0, 12'd4095, 9'd511, 16'hC3C3},
    {1'b0, 1'b0, 12'd4095, 9'd511, 16'h0000},
    {1'b0, 1'b1, 12'd0,    9'd0,   16'h0000},
    {1'b1, 1'b1, 12'd0,    9'd3,   16'hD4D4},
    {1'b0, 1'b0, 12'd0,    9'd3,   16'h0000},
    {1'b0, 1'b0, 12'd0,    9'd4,   16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, burst = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata, dq_out, dq_in = '0;
  logic ready, rvalid, ras_n, cas_n, we_n, dq_oe;
  logic [AB_W-1:0] dram_addr;

  dram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .BURST_LEN(BURST),
    .REF_INT(REF_INT), .REF_ROWS(REF_ROWS), .REF_CYC(REF_CYC)
  ) i_dram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .burst_i(burst), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .rvalid_o(rvalid),
    .dram_addr_o(dram_addr), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .dq_i(dq_in)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req_tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req_tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(int key);
    return 16'(key * 40503) ^ 16'h3C5A;
  endfunction

  // ---------------- DRAM model, sampled mid-cycle ----------------
  logic [15:0] mem [int];
  logic [15:0] shadow [int];
  int cyc = 0, m_row = 0, m_low = 0, fall_cyc = 0, viol = 0, last_row = -1, last_col = -1;
  int ref_rows[$], ref_start[$];
  bit ras_prev = 1, m_cas = 0, rd_v = 0;
  logic [15:0] rd_d = '0;

  always @(negedge clk) begin
    cyc++;
    rd_v = 0;
    if (!rst_n) begin
      ras_prev = 1;
    end else begin
      if (!ras_n) begin
        if (ras_prev) begin
          m_row = int'(dram_addr[ROW_W-1:0]); m_low = 1; m_cas = 0; fall_cyc = cyc;
        end else m_low++;
      end else if (!ras_prev && !m_cas) begin
        if (m_low != REF_CYC) viol++;
        ref_rows.push_back(m_row);
        ref_start.push_back(fall_cyc);
      end
      if (!cas_n) begin
        int key;
        key = m_row * NCOL + int'(dram_addr[COL_W-1:0]);
        if (ras_n || m_low <= T_RCD) viol++;
        m_cas = 1; last_row = m_row; last_col = int'(dram_addr[COL_W-1:0]);
        if (!we_n) begin
          if (!dq_oe) viol++;
          mem[key] = dq_out;
        end else begin
          rd_v = 1;
          rd_d = mem.exists(key) ? mem[key] : pat(key);
        end
      end
      ras_prev = ras_n;
    end
  end

  always @(posedge clk) if (rd_v) dq_in <= rd_d;

  // ---------------- requester ----------------
  bit b_open = 0;
  int b_row = 0;

  task automatic access(bit w, bit b, int row, int col, logic [15:0] wd, bit chk_lat, output int n);
    int nb, lat, beats, lastc, key;
    bit hitb, done;
    logic [15:0] exp;
    nb = (b && !w) ? BURST : 1;
    hitb = b_open && (b_row == row);
    lat = w ? 2 : (b ? BURST + 2 : 3);
    if (!hitb) lat += T_RCD + (b_open ? 1 : 0);
    beats = 0; n = 0; done = 0;
    req = 1; we = w; burst = b; wdata = wd;
    addr = {ROW_W'(row), COL_W'(col)};
    while (!done) begin
      @(posedge clk); @(negedge clk); n++;
      if (rvalid) begin
        key = row * NCOL + (col + beats) % NCOL;
        exp = shadow.exists(key) ? shadow[key] : pat(key);
        chk(rdata == exp, b ? "R5" : "R4", "read data", int'(rdata), int'(exp));
        beats++;
      end
      if (ready || n > 60) done = 1;
    end
    chk(ready == 1'b1, "R7", "ready pulse", int'(ready), 1);
    if (!w) chk(beats == nb, "R5", "read beats", beats, nb);
    if (chk_lat) chk(n == lat, hitb ? "R6" : "R3", "latency", n, lat);
    lastc = (col + nb - 1) % NCOL;
    chk(last_row == row, "R1", "row on bus", last_row, row);
    chk(last_col == lastc, "R1", "column on bus", last_col, lastc);
    if (w) shadow[row * NCOL + col] = wd;
    req = 0; burst = 0; we = 0;
    b_open = 1; b_row = row;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, r0, wt;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(ras_n == 1'b1, "R2", "ras under reset", int'(ras_n), 1);
    chk(cas_n == 1'b1, "R2", "cas under reset", int'(cas_n), 1);
    chk(we_n == 1'b1, "R2", "we under reset", int'(we_n), 1);
    chk(ready == 1'b0, "R2", "ready under reset", int'(ready), 0);
    chk(rvalid == 1'b0, "R2", "rvalid under reset", int'(rvalid), 0);
    chk(dq_oe == 1'b0, "R2", "dq_oe under reset", int'(dq_oe), 0);
    rst_n = 1;
    @(posedge clk); @(negedge clk);

    // vector table: R3 R4 R5 R6 R7 with latency checked
    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][38], VEC[i][37], int'(VEC[i][36:25]), int'(VEC[i][24:16]), VEC[i][15:0], 1, n);
    end
    chk(viol == 0, "R3", "model timing violations", viol, 0);

    // R8 first refresh, R9 row closed afterwards
    r0 = ref_rows.size();
    wt = 0;
    while (ref_rows.size() == r0 && wt < 2000) begin @(negedge clk); wt++; end
    chk(ref_rows.size() > r0, "R8", "refresh seen", ref_rows.size(), r0 + 1);
    b_open = 0;
    access(1'b0, 1'b0, 0, 3, 16'h0, 0, n);
    chk(n == T_RCD + 3, "R9", "latency after refresh", n, T_RCD + 3);

    wt = 0;
    while (ref_rows.size() < 5 && wt < 3000) begin @(negedge clk); wt++; end
    chk(ref_rows.size() >= 5, "R8", "refresh count", ref_rows.size(), 5);
    for (int i = 0; i < 5 && i < ref_rows.size(); i++)
      chk(ref_rows[i] == i % REF_ROWS, "R8", "refresh row order", ref_rows[i], i % REF_ROWS);
    if (ref_rows.size() >= 5) begin
      chk(ref_start[3] - ref_start[2] == REF_INT, "R8", "refresh spacing", ref_start[3] - ref_start[2], REF_INT);
      chk(ref_start[4] - ref_start[3] == REF_INT, "R8", "refresh spacing", ref_start[4] - ref_start[3], REF_INT);
    end
    chk(viol == 0, "R8", "refresh window length", viol, 0);

    // R9 mixed traffic across refreshes
    r0 = ref_rows.size();
    b_open = 0;
    for (int i = 0; i < 80; i++) begin
      access(i % 3 == 0, i % 4 == 1, (i % 3) * 1000, (i * 37) % NCOL, 16'(i * 257 + 3), 0, n);
    end
    chk(ref_rows.size() > r0, "R9", "refresh during traffic", ref_rows.size(), r0 + 1);
    chk(viol == 0, "R9", "no violation around refresh", viol, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule